// File: doc/BRIEF.md
# Packet Receive Queue with Interrupt

This block is the receive side of a register-mapped packet peripheral. A lower framing layer delivers whole packets as a stream of 32-bit words, marking the first word, the last word, and how many bytes of the last word are valid. The block stores the words of each accepted packet in a circular word buffer. It stores each packet's byte length in a separate small queue. When a packet becomes available it raises an interrupt line to the processor.

Software consumes a packet in two steps. It reads the length register, which returns the byte length of the oldest packet, or zero when nothing is waiting. It then pops the packet's words one at a time from the data register. Packets that arrive while software is still draining do not raise a new interrupt. Software therefore keeps reading lengths until it sees zero. The status register uses a write-then-read selector to show the receive counters. Writing zero to the status register resets the whole receive side.

Top module: `pktrx_queue`

## Requirements
- R1: A read of the length register (address 2) returns the byte length of the oldest stored packet and removes it from the length queue. It returns 0 when no packet is stored. At most LQ_DEPTH packets are held at once.
- R2: After a length read returns L > 0, the next (L+3)/4 data register reads (address 1) return that packet's words in arrival order. Byte 0 of the packet is in bits 31:24. On the last word, the byte-count code in_last_bytes (0 means 4 valid bytes, 1 to 3 mean that many) selects which leading bytes are kept, and the trailing bytes read as zero.
- R3: irq rises on the clock edge that stores a packet into an empty queue, unless a read sequence is open. It falls on a length read that removes a packet.
- R4: A read sequence opens with a length read that returns a non-zero value and closes with a length read that returns zero. Packets stored while a sequence is open raise no interrupt.
- R5: A data register read when no packet words remain to be read returns 0 and does not move the queue.
- R6: A length read made before all words of the current packet were read discards that packet's remaining words and then behaves as in R1.
- R7: An incoming packet is discarded as a whole and counted as dropped in either of two cases: its words exceed the free word space, or the length queue is full at its last word. Any of its words already written are abandoned, and stored packets are unaffected.
- R8: Writing a selector value to the status register (address 0) picks what later status reads return: 5 gives the number of queued packets, 6 the number of stored packets since reset, 7 the number of dropped packets. Any other selector reads 0.
- R9: Writing 0 to the status register empties both queues and abandons any partly received packet. It also clears the counters, the selector, the interrupt and the read sequence.
- R10: Words that arrive without a start marker while no packet is open are ignored.
- R11: Writes to the data or length register do not change the receive state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An incoming word is present this cycle |
| in_sop | input | 1 | Incoming word is the first of a packet |
| in_eop | input | 1 | Incoming word is the last of a packet |
| in_last_bytes | input | 2 | Valid bytes in the last word; 0 means 4 |
| in_data | input | 32 | Incoming word, first byte in bits 31:24 |
| reg_addr | input | 2 | Register select: 0 status, 1 data, 2 length, 3 spare |
| reg_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register, valid during the strobe |
| irq | output | 1 | Packet-ready interrupt |

## Verification
The assertions check several conditions on every cycle. An empty queue always yields a zero length. A raised interrupt always has a packet behind it. A stored packet is always either flagged or inside an open read sequence. An open sequence never produces an interrupt edge. An idle data read neither returns data nor moves the read pointer. The word buffer never holds more than its depth. A reset write leaves both queues, the interrupt and the sequence cleared. Only the bench's scenarios show the contents of each packet: byte order, masking of the last word across every length in the sweep, and the exact words after a skipped remainder. They also cover which packets are dropped when space or length slots run out, and the counter values reported through the selector.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_DATA   = 2'd1,
        RA_LENGTH = 2'd2,
        RA_SPARE  = 2'd3
    } rxq_addr_e;

    localparam logic [2:0] SEL_QUEUED   = 3'd5;
    localparam logic [2:0] SEL_RECEIVED = 3'd6;
    localparam logic [2:0] SEL_DROPPED  = 3'd7;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [1:0]        last_bytes;
        logic [WORD_W-1:0] data;
    } rxq_beat_t;

    // Number of valid bytes encoded by the last-word code (0 stands for 4).
    function automatic logic [2:0] byte_count(input logic [1:0] code);
        return (code == 2'd0) ? 3'd4 : {1'b0, code};
    endfunction

    // Keeps the leading valid bytes of a left-aligned final word.
    function automatic logic [WORD_W-1:0] keep_mask(input logic [1:0] code);
        logic [WORD_W-1:0] m;
        case (code)
            2'd1:    m = 32'hFF00_0000;
            2'd2:    m = 32'hFFFF_0000;
            2'd3:    m = 32'hFFFF_FF00;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rxq_word_mem.sv
module rxq_word_mem #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/rxq_len_fifo.sv
module rxq_len_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 2,
    parameter int CW    = 3,
    parameter int W     = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_len,
    input  logic          pop,
    output logic [W-1:0]  head_len,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  slot_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign head_len = slot_q[rd_q];
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) slot_q[wr_q] <= push_len;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/rxq_ingress.sv
module rxq_ingress
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 5,
    parameter int LEN_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              beat_valid,
    input  rxq_beat_t         beat,
    input  logic [PW-1:0]     rd_ptr,
    input  logic              len_full,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              commit,
    output logic [LEN_W-1:0]  commit_len,
    output logic              drop,
    output logic [PW-1:0]     tent_ptr
);

    logic          open_q, ovf_q;
    logic [PW-1:0] base_q, tent_q, cnt_q;

    logic          take, fits, room, end_pkt, bad, cur_ovf;
    logic [PW-1:0] cur_ptr, cur_cnt, used, nxt_ptr;

    always_comb begin
        take     = beat_valid && (beat.sop || open_q);
        cur_ptr  = beat.sop ? base_q : tent_q;
        cur_cnt  = beat.sop ? '0 : cnt_q;
        cur_ovf  = beat.sop ? 1'b0 : ovf_q;
        used     = cur_ptr - rd_ptr;
        room     = (used != PW'(DEPTH));
        fits     = !cur_ovf && room;
        nxt_ptr  = cur_ptr + 1'b1;
        end_pkt  = take && beat.eop;
        bad      = !fits || len_full;

        mem_we     = take && fits;
        mem_waddr  = cur_ptr[AW-1:0];
        mem_wdata  = beat.eop ? (beat.data & keep_mask(beat.last_bytes)) : beat.data;
        commit     = end_pkt && !bad;
        drop       = end_pkt && bad;
        commit_len = LEN_W'({cur_cnt, 2'b00}) + LEN_W'(byte_count(beat.last_bytes));
    end

    assign tent_ptr = tent_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            open_q <= 1'b0;
            ovf_q  <= 1'b0;
            base_q <= '0;
            tent_q <= '0;
            cnt_q  <= '0;
        end else if (take) begin
            if (end_pkt) begin
                open_q <= 1'b0;
                ovf_q  <= 1'b0;
                cnt_q  <= '0;
                if (commit) begin
                    base_q <= nxt_ptr;
                    tent_q <= nxt_ptr;
                end else begin
                    tent_q <= base_q;
                end
            end else begin
                open_q <= 1'b1;
                ovf_q  <= !fits;
                tent_q <= fits ? nxt_ptr : cur_ptr;
                cnt_q  <= fits ? cur_cnt + 1'b1 : cur_cnt;
            end
        end
    end

endmodule

// File: rtl/rxq_stats.sv
module rxq_stats
    import rxq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LQ_CW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             sel_wr,
    input  logic [2:0]       sel_in,
    input  logic             ev_commit,
    input  logic             ev_drop,
    input  logic [LQ_CW-1:0] queued,
    output logic [WORD_W-1:0] value
);

    localparam int N_EV = 2;

    logic [2:0]       sel_q;
    logic [N_EV-1:0]  ev;
    logic [CNT_W-1:0] cnt_q [N_EV];

    assign ev = {ev_drop, ev_commit};

    always_ff @(posedge clk) begin
        if (rst || flush)  sel_q <= '0;
        else if (sel_wr)   sel_q <= sel_in;
    end

    for (genvar g = 0; g < N_EV; g++) begin : g_evcnt
        always_ff @(posedge clk) begin
            if (rst || flush) cnt_q[g] <= '0;
            else if (ev[g])   cnt_q[g] <= cnt_q[g] + 1'b1;
        end
    end

    always_comb begin
        case (sel_q)
            SEL_QUEUED:   value = WORD_W'(queued);
            SEL_RECEIVED: value = WORD_W'(cnt_q[0]);
            SEL_DROPPED:  value = WORD_W'(cnt_q[1]);
            default:      value = '0;
        endcase
    end

endmodule

// File: rtl/pktrx_queue.sv
module pktrx_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,  // word buffer depth, power of two
    parameter int LQ_DEPTH = 4,   // packets held at once
    parameter int CNT_W    = 16   // event counter width, at most 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [1:0]  in_last_bytes,
    input  logic [31:0] in_data,
    input  logic [1:0]  reg_addr,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    localparam int AW    = $clog2(DEPTH);
    localparam int PW    = AW + 1;
    localparam int LEN_W = AW + 3;
    localparam int LQ_AW = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1;
    localparam int LQ_CW = $clog2(LQ_DEPTH + 1);

    rxq_addr_e addr;
    rxq_beat_t beat;

    logic len_rd, data_rd, stat_wr, flush, sel_wr;
    logic have_pkt, pop, data_pop;

    logic              mem_we, commit, drop, lq_full, lq_empty;
    logic [AW-1:0]     mem_waddr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata, stat_value;
    logic [LEN_W-1:0]  commit_len, lq_head;
    logic [LQ_CW-1:0]  lq_count;
    logic [PW-1:0]     tent_ptr;

    logic [PW-1:0]     rd_ptr_q, words_left_q, head_words;
    logic [LEN_W:0]    head_round;
    logic              in_seq_q, irq_q;

    assign addr = rxq_addr_e'(reg_addr);
    assign beat = '{sop: in_sop, eop: in_eop, last_bytes: in_last_bytes, data: in_data};

    assign len_rd   = reg_rd && (addr == RA_LENGTH);
    assign data_rd  = reg_rd && (addr == RA_DATA);
    assign stat_wr  = reg_wr && (addr == RA_STATUS);
    assign flush    = stat_wr && (reg_wdata == '0);
    assign sel_wr   = stat_wr && (reg_wdata != '0);
    assign have_pkt = !lq_empty;
    assign pop      = len_rd && have_pkt;
    assign data_pop = data_rd && (words_left_q != '0);

    assign head_round = (LEN_W + 1)'(lq_head) + (LEN_W + 1)'(3);
    assign head_words = PW'(head_round >> 2);

    rxq_ingress #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .LEN_W(LEN_W)) u_ingress (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .beat_valid (in_valid),
        .beat       (beat),
        .rd_ptr     (rd_ptr_q),
        .len_full   (lq_full),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .commit     (commit),
        .commit_len (commit_len),
        .drop       (drop),
        .tent_ptr   (tent_ptr)
    );

    rxq_word_mem #(.DEPTH(DEPTH), .AW(AW), .W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_ptr_q[AW-1:0]),
        .rdata (mem_rdata)
    );

    rxq_len_fifo #(.DEPTH(LQ_DEPTH), .AW(LQ_AW), .CW(LQ_CW), .W(LEN_W)) u_lenq (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push     (commit),
        .push_len (commit_len),
        .pop      (pop),
        .head_len (lq_head),
        .count    (lq_count),
        .full     (lq_full),
        .empty    (lq_empty)
    );

    rxq_stats #(.CNT_W(CNT_W), .LQ_CW(LQ_CW)) u_stats (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .sel_wr    (sel_wr),
        .sel_in    (reg_wdata[2:0]),
        .ev_commit (commit),
        .ev_drop   (drop),
        .queued    (lq_count),
        .value     (stat_value)
    );

    // Read side: word pointer, words still owed for the current packet,
    // read-sequence flag and interrupt.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr_q     <= '0;
            words_left_q <= '0;
            in_seq_q     <= 1'b0;
            irq_q        <= 1'b0;
        end else begin
            if (len_rd) begin
                rd_ptr_q     <= rd_ptr_q + words_left_q;
                words_left_q <= pop ? head_words : '0;
                in_seq_q     <= have_pkt;
                irq_q        <= commit && !have_pkt;
            end else begin
                if (data_pop) begin
                    rd_ptr_q     <= rd_ptr_q + 1'b1;
                    words_left_q <= words_left_q - 1'b1;
                end
                if (commit && lq_empty && !in_seq_q) irq_q <= 1'b1;
            end
        end
    end

    assign irq = irq_q;

    always_comb begin
        case (addr)
            RA_STATUS: reg_rdata = stat_value;
            RA_DATA:   reg_rdata = data_pop ? mem_rdata : '0;
            RA_LENGTH: reg_rdata = have_pkt ? WORD_W'(lq_head) : '0;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    parameter int PW    = 5,
    parameter int LQ_CW = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             len_rd,
    input logic             data_rd,
    input logic             flush,
    input logic [31:0]      rdata,
    input logic [LQ_CW-1:0] lq_count,
    input logic             in_seq,
    input logic [PW-1:0]    words_left,
    input logic [PW-1:0]    rd_ptr,
    input logic [PW-1:0]    tent_ptr
);

    a_r1_empty_len_zero: assert property (@(posedge clk) disable iff (rst)
        (len_rd && lq_count == '0) |-> (rdata == '0));

    a_r3_irq_has_packet: assert property (@(posedge clk) disable iff (rst)
        irq |-> (lq_count != '0));

    a_r3_packet_flagged: assert property (@(posedge clk) disable iff (rst)
        (lq_count != '0) |-> (irq || in_seq));

    a_r3_pop_clears_irq: assert property (@(posedge clk) disable iff (rst)
        (len_rd && lq_count != '0) |=> !irq);

    a_r4_quiet_in_seq: assert property (@(posedge clk) disable iff (rst)
        (in_seq && !len_rd) |=> !$rose(irq));

    a_r5_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
        (data_rd && words_left == '0) |-> (rdata == '0));

    a_r5_idle_data_still: assert property (@(posedge clk) disable iff (rst)
        (data_rd && words_left == '0) |=> $stable(rd_ptr));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (PW'(tent_ptr - rd_ptr) <= PW'(DEPTH)));

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (lq_count == '0 && !irq && !in_seq && words_left == '0));

endmodule

bind pktrx_queue rxq_checker #(.DEPTH(DEPTH), .PW(PW), .LQ_CW(LQ_CW)) u_rxq_checker (
    .clk        (clk),
    .rst        (rst),
    .irq        (irq),
    .len_rd     (len_rd),
    .data_rd    (data_rd),
    .flush      (flush),
    .rdata      (reg_rdata),
    .lq_count   (lq_count),
    .in_seq     (in_seq_q),
    .words_left (words_left_q),
    .rd_ptr     (rd_ptr_q),
    .tent_ptr   (tent_ptr)
);

// File: tb/test_pktrx_queue.sv
module test_pktrx_queue;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sop, in_eop;
    logic [1:0]  in_last_bytes;
    logic [31:0] in_data;
    logic [1:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    int exp_rx = 0;
    int exp_drop = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pktrx_queue i_pktrx_queue (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_last_bytes(in_last_bytes), .in_data(in_data),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [7:0] pbyte(int pid, int i);
        return 8'((pid * 37 + i * 11 + 5) % 256);
    endfunction

    // Expected stored word: bytes past the packet end read as zero.
    function automatic logic [31:0] exp_word(int pid, int len, int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 4; b++) begin
            if (4 * w + b < len) v[31 - 8 * b -: 8] = pbyte(pid, 4 * w + b);
        end
        return v;
    endfunction

    // Driven word: bytes past the packet end carry filler.
    function automatic logic [31:0] drv_word(int pid, int len, int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 4; b++) begin
            v[31 - 8 * b -: 8] = (4 * w + b < len) ? pbyte(pid, 4 * w + b) : 8'hA5;
        end
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic beat(logic sop, logic eop, logic [1:0] lb, logic [31:0] d);
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_last_bytes = lb; in_data = d;
        tick();
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_pkt(int pid, int len);
        int nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++)
            beat(w == 0, w == nw - 1, 2'(len % 4), drv_word(pid, len, w));
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic stat(logic [2:0] sel, output logic [31:0] d);
        reg_write(2'd0, 32'(sel));
        reg_read(2'd0, d);
    endtask

    task automatic drain(string req, int pid, int len);
        logic [31:0] d;
        reg_read(2'd2, d);
        chk({req, " length"}, d, 32'(len));
        for (int w = 0; w < (len + 3) / 4; w++) begin
            reg_read(2'd1, d);
            chk({req, " word"}, d, exp_word(pid, len, w));
        end
    endtask

    task automatic expect_zero_len(string req);
        logic [31:0] d;
        reg_read(2'd2, d);
        chk({req, " zero length"}, d, 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; in_valid = 0; in_sop = 0; in_eop = 0; in_last_bytes = 0; in_data = 0;
        reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state
        chk("R3 irq after reset", 32'(irq), 0);
        expect_zero_len("R1 reset");
        stat(3'd5, d); chk("R8 queued after reset", d, 0);

        // R10: stray word with no open packet
        beat(1'b0, 1'b1, 2'd0, 32'hDEAD_BEEF);
        chk("R10 stray irq", 32'(irq), 0);
        expect_zero_len("R10 stray");

        // R1 R2 R3 R5: sweep of every length up to 40 bytes
        for (int len = 1; len <= 40; len++) begin
            send_pkt(len, len);
            exp_rx++;
            chk("R3 irq on arrival", 32'(irq), 1);
            reg_read(2'd2, d);
            chk("R1 length", d, 32'(len));
            chk("R3 irq cleared by length read", 32'(irq), 0);
            for (int w = 0; w < (len + 3) / 4; w++) begin
                reg_read(2'd1, d);
                chk("R2 word", d, exp_word(len, len, w));
            end
            reg_read(2'd1, d);
            chk("R5 idle data read", d, 0);
            expect_zero_len("R1 drained");
        end

        // R4: arrival during a read sequence
        send_pkt(100, 9); exp_rx++;
        reg_read(2'd2, d); chk("R4 first length", d, 9);
        send_pkt(101, 13); exp_rx++;
        chk("R4 no irq in sequence", 32'(irq), 0);
        for (int w = 0; w < 3; w++) begin
            reg_read(2'd1, d); chk("R4 first words", d, exp_word(100, 9, w));
        end
        drain("R4 second", 101, 13);
        chk("R4 still quiet", 32'(irq), 0);
        expect_zero_len("R4 end");
        send_pkt(102, 6); exp_rx++;
        chk("R4 irq after sequence end", 32'(irq), 1);
        drain("R4 third", 102, 6);
        expect_zero_len("R4 third");

        // R6: skip the rest of a packet
        send_pkt(110, 20); send_pkt(111, 8); exp_rx += 2;
        reg_read(2'd2, d); chk("R6 first length", d, 20);
        reg_read(2'd1, d); chk("R6 first word", d, exp_word(110, 20, 0));
        drain("R6 next packet", 111, 8);
        expect_zero_len("R6 end");

        // R7: word space exhausted
        send_pkt(120, 40); exp_rx++;
        send_pkt(121, 32); exp_drop++;
        stat(3'd5, d); chk("R7 queued after space drop", d, 1);
        drain("R7 survivor", 120, 40);
        expect_zero_len("R7 space");
        send_pkt(122, 70); exp_drop++;
        chk("R7 oversize no irq", 32'(irq), 0);
        expect_zero_len("R7 oversize");

        // R7: length slots exhausted
        for (int p = 0; p < 5; p++) send_pkt(130 + p, 4);
        exp_rx += 4; exp_drop++;
        chk("R3 irq with full queue", 32'(irq), 1);
        stat(3'd5, d); chk("R8 queued", d, 4);
        stat(3'd6, d); chk("R8 received", d, 32'(exp_rx));
        stat(3'd7, d); chk("R8 dropped", d, 32'(exp_drop));
        stat(3'd3, d); chk("R8 unused selector", d, 0);
        for (int p = 0; p < 4; p++) drain("R7 slot survivor", 130 + p, 4);
        expect_zero_len("R7 slots");

        // R11: transmit-side writes leave the receive state alone
        send_pkt(140, 11); exp_rx++;
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_write(2'd2, 32'd5);
        chk("R11 irq kept", 32'(irq), 1);
        drain("R11 packet", 140, 11);
        expect_zero_len("R11");

        // R9: reset write with a stored packet and a partial one
        send_pkt(150, 12);
        beat(1'b1, 1'b0, 2'd0, 32'h1111_2222);
        reg_write(2'd0, 32'd0);
        exp_rx = 0; exp_drop = 0;
        chk("R9 irq cleared", 32'(irq), 0);
        reg_read(2'd0, d); chk("R9 selector cleared", d, 0);
        stat(3'd6, d); chk("R9 received cleared", d, 0);
        stat(3'd7, d); chk("R9 dropped cleared", d, 0);
        stat(3'd5, d); chk("R9 queue emptied", d, 0);
        beat(1'b0, 1'b1, 2'd2, 32'h3333_4444);
        expect_zero_len("R9 partial abandoned");
        send_pkt(151, 7); exp_rx++;
        chk("R9 irq after reset write", 32'(irq), 1);
        drain("R9 new packet", 151, 7);
        expect_zero_len("R9 end");
        stat(3'd6, d); chk("R8 received after reset write", d, 32'(exp_rx));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule